// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a BCD calendar that another block keeps, and raises an alarm interrupt when the programmed alarm time is reached. The calendar arrives on six input fields: seconds, minutes, hours, day of month, month and a three-digit year. A strobe marks the cycle in which those fields have just advanced by one second. Software programs one alarm value per field, a mask that selects which fields take part, and a global enable. It reads the interrupt state back and clears it by writing a one to the status bit.

The comparison runs only in a strobe cycle and only while the global enable is set. The selected fields are OR-combined, so a single selected field that equals its alarm value is enough to fire. The alarm is held in a two-state machine. In `ALM_IDLE` the interrupt is low. The transition *fire* (strobe, global enable and at least one selected field matching) moves it to `ALM_FIRED`, where the interrupt is high. The transition *ack* (a write-one-to-clear with no fire in that cycle) returns it to `ALM_IDLE`. In `ALM_FIRED` with no ack, the transition *hold* keeps it there. When fire and ack fall in the same cycle, fire wins.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset, the control register, all six alarm value registers and the status register read 0, and `alarm_irq` is low.
- R2: The register map is: address 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 status. Each alarm value is stored masked on write to its width: 7 bits for seconds and minutes, 6 bits for hours and day, 5 bits for month, and 12 bits for the year. Control keeps 7 bits. Reads are zero-extended.
- R3: Control bits 0 to 5 select the fields seconds, minutes, hours, day, month and year, in that order. A field whose bit is clear never causes a fire. The comparison uses the full input width: 8 bits for the two-digit fields and 12 bits for the year.
- R4: While control bit 6 (global enable) is 0, no strobe causes a fire.
- R5: A fire occurs when any one selected field equals its alarm value. The other selected fields do not need to match.
- R6: Evaluation happens only in a cycle where `sec_tick` is high, using the field values present in that cycle. On a fire, `alarm_irq` is high from the next clock edge.
- R7: Once set, `alarm_irq` stays high until it is cleared, even when later strobes do not match.
- R8: A write to address 7 with data bit 1 set clears the alarm from the next edge. A write to address 7 with bit 1 clear has no effect.
- R9: If a clear write and a fire fall in the same cycle, the alarm stays set.
- R10: Reading address 7 returns the alarm state in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| sec_tick | input | 1 | One-second strobe; time fields are already advanced |
| t_sec | input | 8 | Current seconds, BCD |
| t_min | input | 8 | Current minutes, BCD |
| t_hour | input | 8 | Current hours, BCD |
| t_mday | input | 8 | Current day of month, BCD |
| t_mon | input | 8 | Current month, BCD |
| t_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Sticky alarm interrupt |

## Verification
The two functions that can meet in one cycle are a software clear of the alarm and a new fire from a matching strobe. The bench provokes this by writing one to status bit 1 in the very cycle in which `sec_tick` presents a day value equal to the programmed alarm day. It judges the result by expecting `alarm_irq` still high after that edge. It then expects the interrupt to drop after a following clear that has no strobe.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int VAL_W      = 12;
    localparam int ADDR_W     = 3;
    localparam int CTRL_W     = 7;
    localparam int GLOBAL_BIT = 6;
    localparam int STATUS_BIT = 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd7;

    typedef enum logic {
        ALM_IDLE  = 1'b0,
        ALM_FIRED = 1'b1
    } alm_state_t;

    // stored width of each alarm field, index 0 = seconds .. 5 = year
    function automatic int field_width(input int idx);
        case (idx)
            0, 1:    return 7;
            2, 3:    return 6;
            4:       return 5;
            default: return 12;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] field_mask(input int idx);
        return VAL_W'((1 << field_width(idx)) - 1);
    endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [CTRL_W-1:0]                 ctrl,
    output logic [NUM_FIELDS-1:0][VAL_W-1:0]  alm_val
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl <= wr_data[CTRL_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(i + 1);
        localparam logic [VAL_W-1:0]  FMASK = field_mask(i);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alm_val[i] <= '0;
            end else if (wr_en && wr_addr == FADDR) begin
                alm_val[i] <= wr_data[VAL_W-1:0] & FMASK;
            end
        end
    end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0]             field_en,
    input  logic                              global_en,
    input  logic [NUM_FIELDS-1:0][VAL_W-1:0]  cur_val,
    input  logic [NUM_FIELDS-1:0][VAL_W-1:0]  alm_val,
    output logic                              any_hit
);
    logic [NUM_FIELDS-1:0] hit;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        assign hit[i] = field_en[i] && (cur_val[i] == alm_val[i]);
    end

    assign any_hit = global_en && (|hit);
endmodule

// File: rtl/cal_alarm_status.sv
module cal_alarm_status
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    output logic irq
);
    alm_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ALM_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ALM_IDLE:  if (fire) state_nx = ALM_FIRED;
            ALM_FIRED: if (ack && !fire) state_nx = ALM_IDLE;
            default:   state_nx = ALM_IDLE;
        endcase
    end

    always_comb begin
        irq = (state == ALM_FIRED);
    end

    assert_set_on_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fire) |=> !irq);
    assert_fire_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && fire) |=> irq);
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sec_tick,
    input  logic [7:0]        t_sec,
    input  logic [7:0]        t_min,
    input  logic [7:0]        t_hour,
    input  logic [7:0]        t_mday,
    input  logic [7:0]        t_mon,
    input  logic [11:0]       t_year,
    output logic              alarm_irq
);
    logic [CTRL_W-1:0]                ctrl;
    logic [NUM_FIELDS-1:0][VAL_W-1:0] alm_val;
    logic [NUM_FIELDS-1:0][VAL_W-1:0] cur_val;
    logic                             any_hit;
    logic                             fire;
    logic                             ack;

    cal_alarm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .alm_val (alm_val)
    );

    assign cur_val[0] = VAL_W'(t_sec);
    assign cur_val[1] = VAL_W'(t_min);
    assign cur_val[2] = VAL_W'(t_hour);
    assign cur_val[3] = VAL_W'(t_mday);
    assign cur_val[4] = VAL_W'(t_mon);
    assign cur_val[5] = t_year;

    cal_alarm_match u_match (
        .field_en  (ctrl[NUM_FIELDS-1:0]),
        .global_en (ctrl[GLOBAL_BIT]),
        .cur_val   (cur_val),
        .alm_val   (alm_val),
        .any_hit   (any_hit)
    );

    assign fire = sec_tick && any_hit;
    assign ack  = wr_en && (wr_addr == ADDR_STATUS) && wr_data[STATUS_BIT];

    cal_alarm_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .ack   (ack),
        .irq   (alarm_irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = DATA_W'(ctrl);
            ADDR_STATUS: rd_data[STATUS_BIT] = alarm_irq;
            default:     rd_data = DATA_W'(alm_val[rd_addr - 3'd1]);
        endcase
    end

    assert_quiet_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq && !(sec_tick && ctrl[GLOBAL_BIT])) |=> !alarm_irq);
    assert_status_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_STATUS) |-> (rd_data == (DATA_W'(alarm_irq) << STATUS_BIT)));
endmodule

// File: tb/cal_alarm_cmp_bench.sv
`timescale 1ns/1ps
module cal_alarm_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sec_tick = 1'b0;
    logic [7:0]  t_sec = '0, t_min = '0, t_hour = '0, t_mday = '0, t_mon = '0;
    logic [11:0] t_year = '0;
    logic        alarm_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        bit    exp_irq;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    cal_alarm_cmp u_cal_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_tick(sec_tick), .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
        .t_mday(t_mday), .t_mon(t_mon), .t_year(t_year), .alarm_irq(alarm_irq)
    );

    // monitor: pops expected interrupt level and compares it mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (alarm_irq !== e.exp_irq) begin
                n_fail++;
                $display("FAIL %s: alarm_irq actual=%0b expected=%0b", e.req, alarm_irq, e.exp_irq);
            end
        end
    end

    // driver: one clock cycle of stimulus, expected irq after that edge
    task automatic cyc(input bit we, input logic [2:0] a, input logic [15:0] d,
                       input bit tk, input bit exp_irq, input string req);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; sec_tick = tk;
        @(posedge clk);
        #1;
        wr_en = 1'b0; sec_tick = 1'b0;
        sb.push_back('{exp_irq, req});
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dd, input logic [7:0] mo, input logic [11:0] y);
        t_sec = s; t_min = m; t_hour = h; t_mday = dd; t_mon = mo; t_year = y;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: read addr %0d actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) rd_check(3'(a), 16'h0000, "R1");
        cyc(0, 0, 0, 0, 0, "R1");

        // R2: masked storage
        cyc(1, 3'd1, 16'hFFFF, 0, 0, "R2");
        cyc(1, 3'd2, 16'hFFFF, 0, 0, "R2");
        cyc(1, 3'd3, 16'hFFFF, 0, 0, "R2");
        cyc(1, 3'd4, 16'hFFFF, 0, 0, "R2");
        cyc(1, 3'd5, 16'hFFFF, 0, 0, "R2");
        cyc(1, 3'd6, 16'hFFFF, 0, 0, "R2");
        cyc(1, 3'd0, 16'hFF80, 0, 0, "R2");
        rd_check(3'd1, 16'h007F, "R2");
        rd_check(3'd2, 16'h007F, "R2");
        rd_check(3'd3, 16'h003F, "R2");
        rd_check(3'd4, 16'h003F, "R2");
        rd_check(3'd5, 16'h001F, "R2");
        rd_check(3'd6, 16'h0FFF, "R2");
        rd_check(3'd0, 16'h0000, "R2");

        // program alarm 12:15:30, day 25, month 06, year 123
        cyc(1, 3'd1, 16'h0030, 0, 0, "R2");
        cyc(1, 3'd2, 16'h0015, 0, 0, "R2");
        cyc(1, 3'd3, 16'h0012, 0, 0, "R2");
        cyc(1, 3'd4, 16'h0025, 0, 0, "R2");
        cyc(1, 3'd5, 16'h0006, 0, 0, "R2");
        cyc(1, 3'd6, 16'h0123, 0, 0, "R2");

        // R4: seconds selected but global enable off
        cyc(1, 3'd0, 16'h0001, 0, 0, "R4");
        set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 0, "R4");

        // R6: evaluated only on strobe
        cyc(1, 3'd0, 16'h0041, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, "R6");
        set_time(8'h29, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 0, "R6");
        // R2/R3: wide input with extra high bit does not match
        set_time(8'hB0, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 0, "R3");
        set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 1, "R6");

        // R7: sticky across non-matching strobes
        set_time(8'h31, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 1, "R7");
        cyc(0, 0, 0, 0, 1, "R7");

        // R8: writing bit0 only has no effect; R10 readback
        cyc(1, 3'd7, 16'h0001, 0, 1, "R8");
        rd_check(3'd7, 16'h0002, "R10");
        cyc(1, 3'd7, 16'h0002, 0, 0, "R8");
        rd_check(3'd7, 16'h0000, "R10");

        // R3: minutes only; seconds match ignored
        cyc(1, 3'd0, 16'h0042, 0, 0, "R3");
        set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 0, "R3");
        set_time(8'h00, 8'h15, 8'h00, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 1, "R3");
        cyc(1, 3'd7, 16'h0002, 0, 0, "R8");

        // R5: all but seconds selected, single-field matches fire
        cyc(1, 3'd0, 16'h007E, 0, 0, "R5");
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h123);
        cyc(0, 0, 0, 1, 1, "R5");
        cyc(1, 3'd7, 16'h0002, 0, 0, "R8");
        set_time(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 12'h000);
        cyc(0, 0, 0, 1, 1, "R5");
        // R9: clear in the same cycle as a day match
        set_time(8'h00, 8'h00, 8'h00, 8'h25, 8'h01, 12'h000);
        cyc(1, 3'd7, 16'h0002, 1, 1, "R9");
        cyc(1, 3'd7, 16'h0002, 0, 0, "R9");
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 12'h000);
        cyc(0, 0, 0, 1, 1, "R5");
        cyc(1, 3'd7, 16'h0002, 0, 0, "R8");

        // R3: year compares all three digits
        cyc(1, 3'd0, 16'h0060, 0, 0, "R3");
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h023);
        cyc(0, 0, 0, 1, 0, "R3");
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h123);
        cyc(0, 0, 0, 1, 1, "R3");

        cyc(0, 0, 0, 0, 1, "R7");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule